// File: doc/BRIEF.md
# Masked Flow Classification Engine

The block gives each packet header a flow identifier. A header parser presents one 112-bit lookup key, built from the address, port, protocol and payload-match fields, and raises `key_valid` for one cycle. Every stored rule compares that key at the same time. A rule holds a value, a care mask and a 16-bit flow identifier. Key bits whose mask bit is clear are ignored.

When several rules match, the one with the lowest index wins. On the next clock edge the engine returns the winner's identifier on `flow_id`, together with a `hit` flag and a one-cycle `result_valid` pulse. Software or a control agent fills the rule table through a single-cycle write port. A write sets the rule's valid bit. Reset clears every valid bit.

A small two-state machine sequences the result. In ST_IDLE no result is presented. The transition IDLE->SHOW is taken when `key_valid` is high. In ST_SHOW `result_valid` is high. SHOW->SHOW is taken on a back-to-back key, and SHOW->IDLE is taken when no key arrives.

Top module: `flow_classifier`

## Requirements
- R1: Key bit layout from bit 111 down to bit 0: source address [111:80], destination address [79:48], source port [47:32], destination port [31:16], protocol [15:8], payload match bits [7:0]. Value and mask words use the same layout.
- R2: A valid rule matches when, at every bit position where its mask bit is 1, the key bit equals the stored value bit. Key bits at positions where the mask bit is 0 have no effect on the match.
- R3: Reset clears the valid bit of every rule. A rule that is not valid never matches, so a lookup after reset and before any write reports a miss.
- R4: When more than one rule matches, the result is the flow identifier of the matching rule with the lowest index.
- R5: When no rule matches, `hit` is 0 and `flow_id` is 16'h0000.
- R6: A write with `wr_en`=1 stores value, mask and flow identifier at `wr_idx`, marks that rule valid, and replaces whatever that rule held before.
- R7: A lookup presented in the same cycle as a write is resolved against the table contents from before that write. The next lookup sees the written rule.
- R8: `hit` and `flow_id` update in the cycle after `key_valid`=1, and `result_valid` is 1 in exactly those cycles. In cycles after `key_valid`=0, `result_valid` is 0 and `hit` and `flow_id` keep their previous values.
- R9: While reset is asserted and directly after it, `result_valid`, `hit` and `flow_id` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | 3 | Index of the rule being written |
| wr_value | input | 112 | Rule value word |
| wr_mask | input | 112 | Rule care mask (1 = compare this bit) |
| wr_flow | input | 16 | Rule flow identifier |
| key_valid | input | 1 | Lookup strobe |
| key | input | 112 | Lookup key |
| result_valid | output | 1 | One-cycle result pulse |
| hit | output | 1 | A rule matched |
| flow_id | output | 16 | Flow identifier of the winning rule, or 0 on a miss |

## Verification
Directed rules that care about a single field, such as only the protocol byte or only the top of the source address, are probed with keys that differ from the stored value only inside that field or only outside it. This separates correct field placement and masking from off-by-one field positions. Keys that match two rules at once show whether the lowest index really wins. A write issued in the same cycle as a lookup shows whether the old contents are used. A long run of random rules with sparse care masks is then probed with keys derived from one rule's value. Some of these keys have a cared bit flipped, which mixes single hits, multiple hits and near misses.

// File: rtl/flow_cls_pkg.sv
package flow_cls_pkg;

    typedef struct packed {
        logic [31:0] src_addr;
        logic [31:0] dst_addr;
        logic [15:0] src_port;
        logic [15:0] dst_port;
        logic [7:0]  proto;
        logic [7:0]  pmatch;
    } hdr_key_t;

    localparam int KEY_W  = $bits(hdr_key_t);
    localparam int FLOW_W = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } res_state_t;

endpackage

// File: rtl/flow_rule_store.sv
module flow_rule_store
    import flow_cls_pkg::*;
#(
    parameter int N_RULES = 8,
    localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [KEY_W-1:0]                 wr_value,
    input  logic [KEY_W-1:0]                 wr_mask,
    input  logic [FLOW_W-1:0]                wr_flow,
    output logic [N_RULES-1:0][KEY_W-1:0]    rule_value,
    output logic [N_RULES-1:0][KEY_W-1:0]    rule_mask,
    output logic [N_RULES-1:0][FLOW_W-1:0]   rule_flow,
    output logic [N_RULES-1:0]               rule_vld
);

    for (genvar g = 0; g < N_RULES; g++) begin : g_rule
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rule_value[g] <= '0;
                rule_mask[g]  <= '0;
                rule_flow[g]  <= '0;
                rule_vld[g]   <= 1'b0;
            end else if (sel) begin
                rule_value[g] <= wr_value;
                rule_mask[g]  <= wr_mask;
                rule_flow[g]  <= wr_flow;
                rule_vld[g]   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flow_rule_match.sv
module flow_rule_match
    import flow_cls_pkg::*;
#(
    parameter int N_RULES = 8
) (
    input  logic [KEY_W-1:0]                 key,
    input  logic [N_RULES-1:0][KEY_W-1:0]    rule_value,
    input  logic [N_RULES-1:0][KEY_W-1:0]    rule_mask,
    input  logic [N_RULES-1:0]               rule_vld,
    output logic [N_RULES-1:0]               match
);

    for (genvar g = 0; g < N_RULES; g++) begin : g_cmp
        logic [KEY_W-1:0] diff;
        assign diff     = (key ^ rule_value[g]) & rule_mask[g];
        assign match[g] = rule_vld[g] && (diff == '0);
    end

endmodule

// File: rtl/flow_prio_enc.sv
module flow_prio_enc #(
    parameter int N_RULES = 8,
    localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
    input  logic [N_RULES-1:0] match,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        for (int i = N_RULES - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |match;

endmodule

// File: rtl/flow_classifier.sv
module flow_classifier
    import flow_cls_pkg::*;
#(
    parameter int N_RULES = 8,
    localparam int IDX_W = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [KEY_W-1:0]  wr_value,
    input  logic [KEY_W-1:0]  wr_mask,
    input  logic [FLOW_W-1:0] wr_flow,
    input  logic              key_valid,
    input  logic [KEY_W-1:0]  key,
    output logic              result_valid,
    output logic              hit,
    output logic [FLOW_W-1:0] flow_id
);

    logic [N_RULES-1:0][KEY_W-1:0]  rule_value;
    logic [N_RULES-1:0][KEY_W-1:0]  rule_mask;
    logic [N_RULES-1:0][FLOW_W-1:0] rule_flow;
    logic [N_RULES-1:0]             rule_vld;
    logic [N_RULES-1:0]             match;
    logic                           any_match;
    logic [IDX_W-1:0]               win_idx;
    logic [FLOW_W-1:0]              win_flow;

    res_state_t state_q, state_d;
    logic              hit_q;
    logic [FLOW_W-1:0] flow_q;

    flow_rule_store #(.N_RULES(N_RULES)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_value   (wr_value),
        .wr_mask    (wr_mask),
        .wr_flow    (wr_flow),
        .rule_value (rule_value),
        .rule_mask  (rule_mask),
        .rule_flow  (rule_flow),
        .rule_vld   (rule_vld)
    );

    flow_rule_match #(.N_RULES(N_RULES)) match_i (
        .key        (key),
        .rule_value (rule_value),
        .rule_mask  (rule_mask),
        .rule_vld   (rule_vld),
        .match      (match)
    );

    flow_prio_enc #(.N_RULES(N_RULES)) prio_i (
        .match (match),
        .any   (any_match),
        .idx   (win_idx)
    );

    assign win_flow = any_match ? rule_flow[win_idx] : '0;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = key_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = key_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            flow_q <= '0;
        end else if (key_valid) begin
            hit_q  <= any_match;
            flow_q <= win_flow;
        end
    end

    assign result_valid = (state_q == ST_SHOW);
    assign hit          = hit_q;
    assign flow_id      = flow_q;

endmodule

// File: rtl/flow_classifier_chk.sv
module flow_classifier_chk
    import flow_cls_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              key_valid,
    input logic              result_valid,
    input logic              hit,
    input logic [FLOW_W-1:0] flow_id
);

    logic wrote_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
        end else if (wr_en) begin
            wrote_q <= 1'b1;
        end
    end

    assert_result_follows_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> result_valid);

    assert_no_result_without_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> !result_valid);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> ($stable(hit) && $stable(flow_id)));

    assert_miss_zero_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !hit) |-> (flow_id == '0));

    assert_empty_table_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !wrote_q) |-> !hit);

endmodule

bind flow_classifier flow_classifier_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .key_valid    (key_valid),
    .result_valid (result_valid),
    .hit          (hit),
    .flow_id      (flow_id)
);

// File: tb/flow_classifier_tb_top.sv
module flow_classifier_tb_top;
    import flow_cls_pkg::*;

    localparam int N = 8;
    localparam int IW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IW-1:0]     wr_idx = '0;
    logic [KEY_W-1:0]  wr_value = '0;
    logic [KEY_W-1:0]  wr_mask = '0;
    logic [FLOW_W-1:0] wr_flow = '0;
    logic              key_valid = 1'b0;
    logic [KEY_W-1:0]  key = '0;
    logic              result_valid;
    logic              hit;
    logic [FLOW_W-1:0] flow_id;

    always #4 clk = ~clk;

    flow_classifier #(.N_RULES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_flow(wr_flow),
        .key_valid(key_valid), .key(key), .result_valid(result_valid),
        .hit(hit), .flow_id(flow_id)
    );

    logic [KEY_W-1:0]  m_val  [N];
    logic [KEY_W-1:0]  m_mask [N];
    logic [FLOW_W-1:0] m_flow [N];
    logic              m_vld  [N];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void predict(input logic [KEY_W-1:0] k, output logic h, output logic [FLOW_W-1:0] f);
        h = 1'b0;
        f = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_vld[i] && (((k ^ m_val[i]) & m_mask[i]) == '0)) begin
                h = 1'b1;
                f = m_flow[i];
            end
        end
    endfunction

    function automatic logic [KEY_W-1:0] rnd_key();
        logic [KEY_W-1:0] r;
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic model_write(input int idx, input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] m, input logic [FLOW_W-1:0] f);
        m_val[idx] = v; m_mask[idx] = m; m_flow[idx] = f; m_vld[idx] = 1'b1;
    endtask

    task automatic do_write(input int idx, input logic [KEY_W-1:0] v, input logic [KEY_W-1:0] m, input logic [FLOW_W-1:0] f);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_value = v; wr_mask = m; wr_flow = f;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(idx, v, m, f);
    endtask

    task automatic do_lookup(input logic [KEY_W-1:0] k, input string tag);
        logic eh;
        logic [FLOW_W-1:0] ef;
        predict(k, eh, ef);
        key_valid = 1'b1; key = k;
        @(negedge clk);
        key_valid = 1'b0;
        check(result_valid == 1'b1, {tag, " R8 result_valid"}, 64'(result_valid), 64'd1);
        check(hit == eh, {tag, " hit"}, 64'(hit), 64'(eh));
        check(flow_id == ef, {tag, " flow_id"}, 64'(flow_id), 64'(ef));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        hdr_key_t hk;
        logic [KEY_W-1:0] k, pm;
        logic oh;
        logic [FLOW_W-1:0] of_;
        void'($urandom(32'd583));
        for (int i = 0; i < N; i++) begin
            m_val[i] = '0; m_mask[i] = '0; m_flow[i] = '0; m_vld[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(result_valid == 0 && hit == 0 && flow_id == 0, "R9 in reset",
              {47'd0, result_valid, flow_id}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result_valid == 0 && hit == 0 && flow_id == 0, "R9 after reset",
              {47'd0, result_valid, flow_id}, 64'd0);

        // R3: empty table misses even a zero key
        do_lookup('0, "R3 empty zero key");
        do_lookup(rnd_key(), "R3 empty random key");

        // R1/R2: rule 2 cares only about the protocol byte [15:8]
        hk = '0; hk.proto = 8'd6;
        pm = '0; pm[15:8] = 8'hFF;
        do_write(2, hk, pm, 16'h0202);
        k = rnd_key(); k[15:8] = 8'd6;
        do_lookup(k, "R1 R2 proto match");
        check(hit == 1 && flow_id == 16'h0202, "R1 proto direct", 64'(flow_id), 64'h0202);
        k[15:8] = 8'd17;
        do_lookup(k, "R5 proto miss");
        check(hit == 0 && flow_id == 0, "R5 miss zero", 64'(flow_id), 64'h0);

        // R1: rule 4 cares about the top byte of the source address [111:104]
        hk = '0; hk.src_addr = 32'h0A00_0000;
        pm = '0; pm[111:104] = 8'hFF;
        do_write(4, hk, pm, 16'h0404);
        k = '0; k[111:104] = 8'h0A; k[15:8] = 8'd6;
        do_lookup(k, "R4 two hits lowest wins");
        check(flow_id == 16'h0202, "R4 direct", 64'(flow_id), 64'h0202);
        k[15:8] = 8'd1;
        do_lookup(k, "R1 src addr only");
        check(flow_id == 16'h0404, "R1 src direct", 64'(flow_id), 64'h0404);

        // R8: idle cycle keeps result and drops result_valid
        @(negedge clk);
        check(result_valid == 0, "R8 pulse ends", 64'(result_valid), 64'd0);
        check(hit == 1 && flow_id == 16'h0404, "R8 held", 64'(flow_id), 64'h0404);

        // R6: overwrite rule 4 with a destination-port rule
        hk = '0; hk.dst_port = 16'd443;
        pm = '0; pm[31:16] = 16'hFFFF;
        do_write(4, hk, pm, 16'h4444);
        k = '0; k[111:104] = 8'h0A; k[15:8] = 8'd1;
        do_lookup(k, "R6 old rule gone");
        check(hit == 0, "R6 old rule miss", 64'(hit), 64'd0);
        k[31:16] = 16'd443;
        do_lookup(k, "R6 new rule");

        // R7: write and lookup in the same cycle
        k = '0; k[31:16] = 16'd443;
        predict(k, oh, of_);
        wr_en = 1'b1; wr_idx = 3'd0; wr_value = '0; wr_mask = '0; wr_flow = 16'h00AA;
        key_valid = 1'b1; key = k;
        @(negedge clk);
        wr_en = 1'b0; key_valid = 1'b0;
        model_write(0, '0, '0, 16'h00AA);
        check(flow_id == of_ && hit == oh, "R7 old contents used", 64'(flow_id), 64'(of_));
        do_lookup(k, "R7 new contents after");
        check(flow_id == 16'h00AA, "R7 catch-all rule 0", 64'(flow_id), 64'h00AA);

        // random phase
        for (int i = 0; i < N; i++) begin
            do_write(i, rnd_key(), rnd_key() & rnd_key() & rnd_key(), 16'($urandom));
        end
        for (int t = 0; t < 400; t++) begin
            int e;
            e = int'($urandom % N);
            k = (m_val[e] & m_mask[e]) | (rnd_key() & ~m_mask[e]);
            if ($urandom % 4 == 0) k[$urandom % KEY_W] ^= 1'b1;
            if (t % 50 == 49) begin
                do_write(int'($urandom % N), rnd_key(), rnd_key() & rnd_key(), 16'($urandom));
            end
            do_lookup(k, "R2 R4 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule